// File: doc/BRIEF.md
# Enabled-Channel Continuous Scan Sequencer

This block sequences an analog-to-digital conversion controller through every channel that has its bit set in a channel-enable mask. It works through the channels from the lowest number upward and then wraps back to the lowest one. It does this without end for as long as the software start bit stays set. Each channel goes through three stages. First comes a sample stage, flagged on `sample`, that lasts a fixed number of clocks. Then comes a conversion stage, which waits for the converter to raise `conv_done`. Finally comes a one-clock result-write strobe, which carries the index of the channel just converted.

Software sets the start bit with a one-clock pulse on `go_set` and clears it with a one-clock pulse on `go_clr`. The present value of the bit can be read on `run_flag`. A clear drops any conversion in progress. An empty mask cannot start a scan, and if the start bit is set while the mask is empty, hardware removes it.

Top module: `scan_seq`

## Requirements
- R1: Only channels whose `chan_en` bit is 1 are selected, and within a pass they are taken in ascending channel number (mask 0x8D gives 0, 2, 3, 7).
- R2: After the highest enabled channel, the next channel is the lowest enabled one, and passes repeat with no limit on their number.
- R3: `run_flag` is 0 after reset. A one-clock `go_set` pulse sets it, and a one-clock `go_clr` pulse clears it; when both come together the clear wins. Scanning continues while it is 1, and once software has cleared it `sample` stays low.
- R4: `wr_stb` is a one-clock pulse. It comes in the clock after `conv_done` is accepted during the conversion stage, and `wr_idx` (3 bits at 8 channels) carries the channel selected for that conversion.
- R5: At the start of every channel, `sample` is high for exactly SAMPLE_CLKS clocks. After that the conversion stage begins, and only in that stage is `conv_done` accepted.
- R6: If the start bit is cleared during a sample or a conversion, that conversion is dropped and no `wr_stb` is issued for it. `chan_sel` then returns to the lowest enabled channel.
- R7: With `chan_en` all zero, no sample stage starts. A start bit that is set under an all-zero mask reads 1 for one clock and is cleared by hardware on the next clock.
- R8: `chan_sel` does not change from the first clock of a sample stage until the clock edge at which `conv_done` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Channel-enable mask, bit i enables channel i |
| go_set | input | 1 | One-clock pulse that sets the start bit |
| go_clr | input | 1 | One-clock pulse that clears the start bit |
| conv_done | input | 1 | Converter reports the end of the current conversion |
| run_flag | output | 1 | Present value of the start bit |
| chan_sel | output | log2(NCH) | Channel-select lines to the analog multiplexer |
| sample | output | 1 | High during the sample stage |
| wr_stb | output | 1 | One-clock result-write strobe |
| wr_idx | output | log2(NCH) | Result slot (channel index) for `wr_stb` |

## Verification
The bench builds the block with NCH=8, SAMPLE_CLKS=3 and FIND_STYLE=1. With FIND_STYLE=1, both priority finders use the isolate-lowest-bit variant rather than the default loop. A three-clock sample stage combined with a four-clock converter latency lets a clear land either inside the sample stage or inside the conversion stage. The masks used are dense (0xFF), sparse (0x8D, 0x42), single-bit at both ends (0x01, 0x80) and empty. Together they reach wraps from channel 7, repeated conversions of a single channel, and the hardware clear of the start bit.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } scan_st_e;
endpackage

// File: rtl/scan_lowest.sv
// Finds the lowest set bit of a vector and returns its index.
module scan_lowest #(
   parameter int N     = 8,
   parameter int STYLE = 0,
   localparam int W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         hit
);
   assign hit = |vec;

   generate
      if (STYLE == 0) begin : g_loop
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = W'(i);
            end
         end
      end else begin : g_iso
         logic [N-1:0] iso;
         assign iso = vec & (~vec + N'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (iso[i]) idx = idx | W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/scan_pick.sv
// Lowest enabled channel and the next enabled channel above the current one.
module scan_pick #(
   parameter int NCH   = 8,
   parameter int STYLE = 0,
   localparam int CW   = $clog2(NCH)
) (
   input  logic [NCH-1:0] mask,
   input  logic [CW-1:0]  cur,
   output logic [CW-1:0]  first,
   output logic [CW-1:0]  nxt,
   output logic           any
);
   logic [NCH-1:0] above;
   logic [CW-1:0]  up_idx;
   logic           up_hit;

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         above[i] = mask[i] && (i > int'(cur));
      end
   end

   scan_lowest #(.N(NCH), .STYLE(STYLE)) u_first (
      .vec (mask),
      .idx (first),
      .hit (any)
   );

   scan_lowest #(.N(NCH), .STYLE(STYLE)) u_up (
      .vec (above),
      .idx (up_idx),
      .hit (up_hit)
   );

   assign nxt = up_hit ? up_idx : first;
endmodule

// File: rtl/scan_smp_timer.sv
// Sample-stage length counter.
module scan_smp_timer #(
   parameter int CLKS = 4,
   localparam int W   = (CLKS > 1) ? $clog2(CLKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= W'(CLKS - 1);
      end else if (run && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/scan_go.sv
// Start bit: software set / clear, hardware clear on an empty mask.
module scan_go (
   input  logic clk,
   input  logic rst_n,
   input  logic set_p,
   input  logic clr_p,
   input  logic any_en,
   output logic run
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
      end else if (clr_p) begin
         run <= 1'b0;
      end else if (run && !any_en) begin
         run <= 1'b0;
      end else if (set_p) begin
         run <= 1'b1;
      end
   end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
   import scan_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int SAMPLE_CLKS = 4,
   parameter int FIND_STYLE  = 0,
   localparam int CW         = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] chan_en,
   input  logic           go_set,
   input  logic           go_clr,
   input  logic           conv_done,
   output logic           run_flag,
   output logic [CW-1:0]  chan_sel,
   output logic           sample,
   output logic           wr_stb,
   output logic [CW-1:0]  wr_idx
);
   generate
      if (NCH < 2) begin : g_bad_nch
         $error("scan_seq: NCH must be at least 2");
      end
      if ((1 << CW) != NCH) begin : g_bad_pow
         $error("scan_seq: NCH must be a power of two");
      end
      if (SAMPLE_CLKS < 1) begin : g_bad_smp
         $error("scan_seq: SAMPLE_CLKS must be at least 1");
      end
      if (FIND_STYLE != 0 && FIND_STYLE != 1) begin : g_bad_style
         $error("scan_seq: FIND_STYLE must be 0 or 1");
      end
   endgenerate

   scan_st_e      st, st_nx;
   logic [CW-1:0] cur, cur_nx;
   logic [CW-1:0] first_ch, next_ch;
   logic          any_en;
   logic          tm_last;
   logic          enter_smp;
   logic          wr_nx;

   scan_go u_go (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_p  (go_set),
      .clr_p  (go_clr),
      .any_en (any_en),
      .run    (run_flag)
   );

   scan_pick #(.NCH(NCH), .STYLE(FIND_STYLE)) u_pick (
      .mask  (chan_en),
      .cur   (cur),
      .first (first_ch),
      .nxt   (next_ch),
      .any   (any_en)
   );

   scan_smp_timer #(.CLKS(SAMPLE_CLKS)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (enter_smp),
      .run   (sample),
      .last  (tm_last)
   );

   always_comb begin
      st_nx  = st;
      cur_nx = cur;
      wr_nx  = 1'b0;
      unique case (st)
         ST_IDLE: begin
            cur_nx = first_ch;
            if (run_flag && any_en) st_nx = ST_SAMPLE;
         end
         ST_SAMPLE: begin
            if (!run_flag) begin
               st_nx  = ST_IDLE;
               cur_nx = first_ch;
            end else if (tm_last) begin
               st_nx = ST_CONV;
            end
         end
         ST_CONV: begin
            if (!run_flag) begin
               st_nx  = ST_IDLE;
               cur_nx = first_ch;
            end else if (conv_done) begin
               wr_nx = 1'b1;
               if (any_en) begin
                  st_nx  = ST_SAMPLE;
                  cur_nx = next_ch;
               end else begin
                  st_nx  = ST_IDLE;
                  cur_nx = first_ch;
               end
            end
         end
         default: begin
            st_nx  = ST_IDLE;
            cur_nx = first_ch;
         end
      endcase
   end

   assign enter_smp = (st_nx == ST_SAMPLE) && (st != ST_SAMPLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cur    <= '0;
         wr_stb <= 1'b0;
         wr_idx <= '0;
      end else begin
         st     <= st_nx;
         cur    <= cur_nx;
         wr_stb <= wr_nx;
         if (wr_nx) wr_idx <= cur;
      end
   end

   assign chan_sel = cur;
   assign sample   = (st == ST_SAMPLE);
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
   import scan_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int SAMPLE_CLKS = 4,
   localparam int CW         = $clog2(NCH),
   localparam int LW         = $clog2(SAMPLE_CLKS + 2) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] chan_en,
   input logic           conv_done,
   input logic           run_flag,
   input logic [CW-1:0]  chan_sel,
   input logic           sample,
   input logic           wr_stb,
   input logic [CW-1:0]  wr_idx,
   input scan_st_e       st
);
   logic [NCH-1:0] mask_prev;
   logic [LW-1:0]  run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_prev <= '0;
         run_len   <= '0;
      end else begin
         mask_prev <= chan_en;
         if (sample) run_len <= run_len + 1'b1;
         else        run_len <= '0;
      end
   end

   AST_EN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample) |-> mask_prev[chan_sel]);                          // R1

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_flag |=> !sample);                                          // R3

   AST_WR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);                                             // R4

   AST_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($past(conv_done) && $past(st == ST_CONV)));          // R4

   AST_WR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_idx == $past(chan_sel)));                         // R4

   AST_SMP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sample) && run_flag) |-> (run_len == LW'(SAMPLE_CLKS)));  // R5

   AST_STOP_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
      !run_flag |=> !wr_stb);                                          // R6

   AST_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_flag && chan_en == '0) |=> !run_flag);                      // R7

   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en == '0 && !sample) |=> !sample);                         // R7

   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != ST_IDLE) && run_flag && !(st == ST_CONV && conv_done))
         |=> $stable(chan_sel));                                       // R8
endmodule

bind scan_seq scan_seq_chk #(.NCH(NCH), .SAMPLE_CLKS(SAMPLE_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_en   (chan_en),
   .conv_done (conv_done),
   .run_flag  (run_flag),
   .chan_sel  (chan_sel),
   .sample    (sample),
   .wr_stb    (wr_stb),
   .wr_idx    (wr_idx),
   .st        (st)
);

// File: tb/scan_seq_test.sv
module scan_seq_test;
   localparam int NCH = 8;
   localparam int S   = 3;
   localparam int LAT = 4;

   logic           clk       = 1'b0;
   logic           rst_n     = 1'b0;
   logic [NCH-1:0] chan_en   = '0;
   logic           go_set    = 1'b0;
   logic           go_clr    = 1'b0;
   logic           conv_done = 1'b0;
   logic           run_flag;
   logic [2:0]     chan_sel;
   logic           sample;
   logic           wr_stb;
   logic [2:0]     wr_idx;

   int total = 0;
   int bad   = 0;
   int stray = 0;
   int cyc   = 0;
   int exp_q[$];

   scan_seq #(.NCH(NCH), .SAMPLE_CLKS(S), .FIND_STYLE(1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .go_set    (go_set),
      .go_clr    (go_clr),
      .conv_done (conv_done),
      .run_flag  (run_flag),
      .chan_sel  (chan_sel),
      .sample    (sample),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [NCH-1:0] m);
      for (int i = 0; i < NCH; i++) if (m[i]) return i;
      return 0;
   endfunction

   function automatic int next_en(input logic [NCH-1:0] m, input int c);
      for (int i = c + 1; i < NCH; i++) if (m[i]) return i;
      return lowest(m);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         bad++;
         $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // Monitor + converter model
   logic       prev_smp = 1'b0;
   logic       track    = 1'b0;
   logic [2:0] hold     = '0;
   int         slen     = 0;
   int         pend     = 0;

   always @(negedge clk) begin
      if (wr_stb) begin
         if (exp_q.size() == 0) begin
            stray++;
            check(1'b0, "R3 R6 write with nothing expected", int'(wr_idx), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(wr_idx == e, "R1 R2 R4 write index order", int'(wr_idx), e);
         end
      end
      if (conv_done) begin
         conv_done = 1'b0;
         track     = 1'b0;
      end
      if (!run_flag) track = 1'b0;
      if (track) check(chan_sel == hold, "R8 select stable", int'(chan_sel), int'(hold));
      if (sample && !prev_smp) begin
         hold  = chan_sel;
         track = run_flag;
         slen  = 0;
      end
      if (sample) slen++;
      if (!sample && prev_smp && run_flag) begin
         check(slen == S, "R5 sample length", slen, S);
         pend = LAT;
      end else if (pend > 0) begin
         pend--;
         if (pend == 0) conv_done = 1'b1;
      end
      prev_smp = sample;
   end

   task automatic start_scan(input logic [NCH-1:0] m, input int n);
      int c;
      @(negedge clk);
      chan_en = m;
      c = lowest(m);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(c);
         c = next_en(m, c);
      end
      go_set = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
      while (exp_q.size() != 0) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic stop_and_check(input logic [NCH-1:0] m);
      @(negedge clk);
      go_clr = 1'b1;
      @(negedge clk);
      go_clr = 1'b0;
      repeat (12) @(negedge clk);
      check(run_flag == 1'b0, "R3 start bit cleared by software", int'(run_flag), 0);
      check(sample == 1'b0, "R3 no sampling after clear", int'(sample), 0);
      check(chan_sel == lowest(m), "R6 select back to lowest", int'(chan_sel), lowest(m));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(run_flag == 1'b0, "R3 reset start bit", int'(run_flag), 0);
      check(sample == 1'b0, "R3 reset sample", int'(sample), 0);
      check(wr_stb == 1'b0, "R3 reset strobe", int'(wr_stb), 0);

      // R1 R2: sparse mask, more than two passes; clear lands in sample stage (R6)
      start_scan(8'h8D, 9);
      stop_and_check(8'h8D);
      // R2: single channel at each end
      start_scan(8'h01, 3);
      stop_and_check(8'h01);
      start_scan(8'h80, 3);
      stop_and_check(8'h80);
      // R1 R2: dense mask wrap from channel 7
      start_scan(8'hFF, 10);
      stop_and_check(8'hFF);
      start_scan(8'h42, 5);
      stop_and_check(8'h42);

      // R6: clear during the conversion stage drops the conversion
      start_scan(8'h0C, 2);
      while (!sample) begin @(posedge clk); #1; end
      while (sample)  begin @(posedge clk); #1; end
      stray = 0;
      stop_and_check(8'h0C);
      repeat (LAT + 4) @(negedge clk);
      check(stray == 0, "R6 dropped conversion wrote nothing", stray, 0);

      // R7: empty mask
      @(negedge clk);
      chan_en = '0;
      go_set  = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
      check(run_flag == 1'b1, "R7 set seen under empty mask", int'(run_flag), 1);
      check(sample == 1'b0, "R7 no sample under empty mask", int'(sample), 0);
      @(negedge clk);
      check(run_flag == 1'b0, "R7 hardware clear", int'(run_flag), 0);
      repeat (4) @(negedge clk);
      check(sample == 1'b0, "R7 still idle", int'(sample), 0);
      check(wr_stb == 1'b0, "R7 no write", int'(wr_stb), 0);

      check(exp_q.size() == 0, "R1 all expected writes seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule